// File: doc/BRIEF.md
# Extended Asynchronous Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame is one start bit, then 5 to 17 data bits, then an optional parity bit, then one or two stop bits. The start bit and the data bits go out either as plain levels or Manchester coded. In Manchester mode the parity bit is always left out.

Timing comes from a half-bit tick enable supplied from outside. Every bit lasts two ticks, whatever the encoding. A one-cycle start strobe launches a frame from idle. The block copies the data word and every configuration input when it launches the frame, so changes to those inputs during the frame have no effect. It reports activity on `busy` and pulses `done` once the last stop bit ends.

Top module: `xframe_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `done` is 0 except for its completion pulse.
- R2: Each frame begins with exactly one start bit of value 0, lasting two half-bit ticks.
- R3: `len` gives the number of data bits directly. The legal values are 5, 6, 7, 8, 9, 13, 14, 15, 16 and 17. Any other value sends 8 bits. A frame lasts 2*(1+n+p+s) ticks, where n is the data bit count, p is the parity bit count and s is the stop bit count.
- R4: With `msb_first`=0 the data bits go out from bit 0 upward. With `msb_first`=1 they go out from bit n-1 downward.
- R5: `par_mode` selects the parity: 00 or 11 is none, 01 is even, 10 is odd. Even parity is the XOR of the n data bits, and odd parity is its inverse. The parity bit is sent after the last data bit and before the first stop bit.
- R6: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two. Stop bits are 1 for both half-bit periods.
- R7: With `manch`=1 the start bit and the data bits are Manchester coded: a 0 is sent as high then low, and a 1 as low then high. No parity bit is sent, whatever `par_mode` holds.
- R8: A `start` that arrives while `busy` is 1 is ignored. `busy` rises in the cycle after an accepted start. `done` is a one-cycle pulse that coincides with `busy` falling after the last stop half-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-bit tick enable |
| start | input | 1 | Frame launch strobe |
| data | input | DW (17) | Character to send |
| len | input | 5 | Data bit count |
| msb_first | input | 1 | Bit order select |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | Stop bit count select |
| manch | input | 1 | Manchester select |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame end pulse |

## Verification
The bench builds the block with the default DW of 17. This makes both ends of the length range reachable, from the 5-bit minimum to the full 17-bit word. It also covers the 9-to-13 gap and values outside the legal set, such as 0, 10, 12 and 31. Tick spacings of one and three cycles are used, together with back-to-back frames launched by a start held high and starts issued in the middle of a frame.

// File: rtl/xframe_tx.sv
module xframe_tx #(
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic [4:0]    len,
  input  logic          msb_first,
  input  logic [1:0]    par_mode,
  input  logic          two_stop,
  input  logic          manch,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int LW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic          half, stop_idx;
  logic [LW-1:0] pos, len_q;
  logic [DW-1:0] data_q;
  logic          msb_q, two_q, man_q, par_en_q, par_q;

  logic          len_ok;
  logic [LW-1:0] len_eff;
  logic          par_calc, cur, bitsel;
  logic [LW-1:0] idx;

  assign len_ok  = ((len >= 5 && len <= 9) || (len >= 13 && len <= 17)) && (int'(len) <= DW);
  assign len_eff = len_ok ? LW'(len) : LW'(8);

  always_comb begin
    par_calc = par_mode[1];
    for (int i = 0; i < DW; i++)
      if (i < int'(len_eff)) par_calc ^= data[i];
  end

  assign busy   = (st != S_IDLE);
  assign idx    = msb_q ? LW'(len_q - pos - 1'b1) : pos;
  assign bitsel = data_q[idx];

  always_comb begin
    case (st)
      S_START: cur = 1'b0;
      S_DATA:  cur = bitsel;
      S_PAR:   cur = par_q;
      default: cur = 1'b1;
    endcase
  end

  assign txd = (man_q && (st == S_START || st == S_DATA)) ? (half ? cur : ~cur) : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; half <= 1'b0; stop_idx <= 1'b0; pos <= '0; len_q <= LW'(8);
      data_q <= '0; msb_q <= 1'b0; two_q <= 1'b0; man_q <= 1'b0;
      par_en_q <= 1'b0; par_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st       <= S_START;
          half     <= 1'b0;
          stop_idx <= 1'b0;
          pos      <= '0;
          len_q    <= len_eff;
          data_q   <= data;
          msb_q    <= msb_first;
          two_q    <= two_stop;
          man_q    <= manch;
          par_en_q <= !manch && (par_mode == 2'b01 || par_mode == 2'b10);
          par_q    <= par_calc;
        end
      end else if (tick) begin
        half <= ~half;
        if (half) begin
          case (st)
            S_START: begin st <= S_DATA; pos <= '0; end
            S_DATA:
              if (pos == len_q - 1'b1) st <= par_en_q ? S_PAR : S_STOP;
              else pos <= pos + 1'b1;
            S_PAR: st <= S_STOP;
            S_STOP:
              if (two_q && !stop_idx) stop_idx <= 1'b1;
              else begin st <= S_IDLE; done <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && !man_q) |-> !txd);
  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((len_q >= 5 && len_q <= 9) || (len_q >= 13 && len_q <= 17)));
  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> txd);
  assert_no_par_manch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    man_q |-> (st != S_PAR));
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(data_q));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/xframe_tx_bench.sv
module xframe_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 17;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [4:0] len = 5'd8;
  logic msb_first = 1'b0, two_stop = 1'b0, manch = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic txd, busy, done;

  int errors = 0, checks = 0, tick_period = 1, tick_cnt = 0;
  int q[$];
  bit busy_m = 0, done_m = 0;
  int exp_halves = 0, seen_ticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xframe_tx #(.DW(DW)) u_xframe_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .data(data),
    .len(len), .msb_first(msb_first), .par_mode(par_mode), .two_stop(two_stop),
    .manch(manch), .txd(txd), .busy(busy), .done(done));

  function automatic string tagname(int t);
    case (t)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void push_bit(bit v, bit man, int tag);
    if (man) begin q.push_back(((~v) & 1) | (tag << 1)); q.push_back(v | (tag << 1)); end
    else     begin q.push_back(v | (tag << 1));          q.push_back(v | (tag << 1)); end
  endfunction

  function automatic void build();
    int n;
    bit p;
    n = ((len >= 5 && len <= 9) || (len >= 13 && len <= 17)) ? int'(len) : 8;
    push_bit(1'b0, manch, manch ? 5 : 1);
    p = 0;
    for (int i = 0; i < n; i++) begin
      bit b;
      b = msb_first ? data[n-1-i] : data[i];
      p ^= b;
      push_bit(b, manch, manch ? 5 : 2);
    end
    if (!manch && (par_mode == 2'b01 || par_mode == 2'b10))
      push_bit(p ^ (par_mode == 2'b10), 1'b0, 3);
    push_bit(1'b1, 1'b0, 4);
    if (two_stop) push_bit(1'b1, 1'b0, 4);
    exp_halves = q.size();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); busy_m = 0; done_m = 0;
    end else begin
      if (busy && tick) seen_ticks++;
      if (busy_m) begin
        done_m = 0;
        if (tick) void'(q.pop_front());
        if (q.size() == 0) begin busy_m = 0; done_m = 1; end
      end else begin
        done_m = 0;
        if (start) begin build(); busy_m = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_m) check(tagname(q[0] >> 1), int'(txd), q[0] & 1, "line level");
      else        check("R1", int'(txd), 1, "idle line");
      check("R8", int'(busy), int'(busy_m), "busy");
      check("R8", int'(done), int'(done_m), "done");
      if (done) begin
        check("R3", seen_ticks, exp_halves, "ticks per frame");
        seen_ticks = 0;
      end
    end
  end

  always @(negedge clk) begin
    tick_cnt++;
    if (tick_cnt >= tick_period) begin tick <= 1'b1; tick_cnt = 0; end
    else tick <= 1'b0;
  end

  task automatic send(logic [DW-1:0] d, logic [4:0] l, bit m, logic [1:0] pm, bit ts, bit mc, bit poke);
    while (busy) @(negedge clk);
    data = d; len = l; msb_first = m; par_mode = pm; two_stop = ts; manch = mc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data = ~d; len = 5'd17; msb_first = ~m; par_mode = 2'b10; manch = ~mc;
    repeat (4) @(negedge clk);
    if (poke) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(txd), 1, "reset txd");
    check("R1", int'(busy), 0, "reset busy");
    check("R1", int'(done), 0, "reset done");
    rst_n = 1'b1;
    @(negedge clk);
    send(17'h00015, 5'd5, 0, 2'b01, 0, 0, 0);
    send(17'h000A7, 5'd8, 1, 2'b10, 1, 0, 1);
    send(17'h001F3, 5'd9, 0, 2'b11, 0, 0, 0);
    send(17'h0155A, 5'd13, 1, 2'b01, 1, 0, 0);
    send(17'h1C3A5, 5'd17, 0, 2'b10, 0, 0, 1);
    send(17'h1C3A5, 5'd17, 1, 2'b01, 1, 0, 0);
    send(17'h02D6B, 5'd14, 0, 2'b00, 0, 0, 0);
    send(17'h05A5A, 5'd15, 1, 2'b10, 0, 0, 0);
    send(17'h0F0F1, 5'd16, 0, 2'b01, 1, 0, 0);
    send(17'h0003B, 5'd6, 1, 2'b01, 0, 0, 0);
    send(17'h0005E, 5'd7, 0, 2'b10, 1, 0, 0);
    send(17'h0FFB5, 5'd10, 0, 2'b01, 0, 0, 0);
    send(17'h0FF4C, 5'd0, 1, 2'b00, 0, 0, 0);
    send(17'h1FF96, 5'd31, 0, 2'b10, 1, 0, 0);
    send(17'h00ACE, 5'd12, 1, 2'b01, 0, 0, 0);
    send(17'h0001A, 5'd5, 0, 2'b01, 1, 1, 1);
    send(17'h1B2C3, 5'd17, 1, 2'b10, 0, 1, 0);
    tick_period = 3;
    send(17'h00C9, 5'd8, 0, 2'b01, 1, 0, 1);
    send(17'h1A5F0, 5'd16, 1, 2'b00, 0, 1, 0);
    tick_period = 1;
    data = 17'h00055; len = 5'd5; msb_first = 0; par_mode = 2'b01; two_stop = 0; manch = 0;
    start = 1'b1;
    repeat (60) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule